// File: doc/BRIEF.md
# Obfuscated Scan Chain with Hidden Link Gates

This block is a register of `CHAIN_LEN` flip-flops that serves two purposes. In functional mode every cell captures its bit of a parallel data input on each clock, and the register contents appear on a parallel output. In scan mode the same cells form a serial shift path from `scanIn` through cell 0 up to cell `CHAIN_LEN-1`, whose value drives `scanOut`. This path gives test equipment full control over the register contents and full visibility of them.

To keep the scanned bit stream from mapping directly onto the register contents, some links of the shift path pass through a gate. A build-time bit mask (`LINK_MASK`) selects these links. In the XOR variant, a gated cell takes the XOR of the incoming bit and its own current value. In the inverter variant, a gated cell takes the inverse of the incoming bit. The inverter variant exists so that its weakness can be compared with the XOR variant. After a reset, scanning out the inverter variant shows the gate positions directly. The XOR variant gives only zeros.

Top module: `obf_scan_chain`

## Requirements
- R1: An active-high asynchronous `rst` clears every cell to 0 at once, without waiting for a clock edge. While reset is active, `funcOut` and `scanOut` are 0.
- R2: When `scanEn` is 0, every cell `i` loads `funcIn[i]` on the next rising edge. The mask and the gate variant have no effect on this load.
- R3: When `scanEn` is 1 and mask bit `i` is 0, cell `i` loads the bit on its incoming link. For cell 0 that bit is `scanIn`; for any other cell it is cell `i-1`.
- R4: In the XOR variant (`GATE_KIND = GATE_XOR`), when `scanEn` is 1 and mask bit `i` is 1, cell `i` loads the incoming link bit XOR the current value of cell `i`.
- R5: In the inverter variant (`GATE_KIND = GATE_INV`), when `scanEn` is 1 and mask bit `i` is 1, cell `i` loads the inverse of the incoming link bit.
- R6: `funcOut[i]` is the value of cell `i`. `scanOut` is the value of cell `CHAIN_LEN-1`.
- R7: Mask bit `i` gates the link into cell `i`. Bit 0 gates the link from `scanIn` into cell 0.
- R8: Any captured state can be shifted out in `CHAIN_LEN` scan cycles. Any state can be reached by shifting. The bit stream follows from R3 to R5 for a known mask.
- R9: In the inverter variant, after a reset, shifting with `scanIn` held at 0 for `CHAIN_LEN` cycles produces a `scanOut` stream. Sample `k` of this stream (k = 0 for the first shift) differs from sample `k-1` exactly when mask bit `CHAIN_LEN-1-k` is 1; sample -1 is taken as 0.
- R10: In the XOR variant, after a reset, shifting with `scanIn` held at 0 keeps every cell at 0, so `scanOut` is 0 for every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| scanEn | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| scanIn | input | 1 | Serial bit entering cell 0 |
| funcIn | input | CHAIN_LEN | Parallel data captured in functional mode |
| funcOut | output | CHAIN_LEN | Current cell values |
| scanOut | output | 1 | Value of the last cell |

## Verification
Every output comes straight from a cell, so the effect of a capture or a shift can be seen exactly one rising edge after the inputs that cause it. The effect of a reset can be seen at once, with no edge needed. The bench changes inputs on a falling edge, advances its reference model for that one edge, and compares all outputs at the next falling edge. It compares both variants' whole cell vectors on every cycle. Each bit of a captured word reaches `scanOut` after `CHAIN_LEN-1-i` further shifts. The bench uses this to rebuild the mask from the inverter variant's stream after reset, and to confirm that the XOR variant's stream after reset is all zeros.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;
  typedef enum logic { GATE_XOR = 1'b0, GATE_INV = 1'b1 } gateKind_e;

  typedef struct packed {
    logic capture;
    logic shift;
  } chainStrobe_t;
endpackage

// File: rtl/obf_scan_ctrl.sv
module obf_scan_ctrl
  import scan_chain_pkg::*;
(
  input  logic         scanEn,
  output chainStrobe_t strobes
);
  always_comb begin
    strobes.capture = ~scanEn;
    strobes.shift   = scanEn;
  end
endmodule

// File: rtl/obf_scan_datapath.sv
module obf_scan_datapath
  import scan_chain_pkg::*;
#(
  parameter int                   CHAIN_LEN = 8,
  parameter logic [CHAIN_LEN-1:0] LINK_MASK = 8'b1010_0101,
  parameter gateKind_e            GATE_KIND = GATE_XOR
) (
  input  logic                 clk,
  input  logic                 rst,
  input  chainStrobe_t         strobes,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcIn,
  output logic [CHAIN_LEN-1:0] cells
);
  localparam int LAST = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] linkBit;
  logic [CHAIN_LEN-1:0] shiftVal;

  genvar i;
  generate
    for (i = 0; i < CHAIN_LEN; i++) begin : gLink
      if (i == 0) begin : gHead
        assign linkBit[i] = scanIn;
      end else begin : gBody
        assign linkBit[i] = cells[i-1];
      end

      if (!LINK_MASK[i]) begin : gPlain
        assign shiftVal[i] = linkBit[i];
        AST_PLAIN_LINK: assert property (@(posedge clk) disable iff (rst)
          strobes.shift |=> cells[i] == $past(linkBit[i])); // R3
      end else if (GATE_KIND == GATE_INV) begin : gInv
        assign shiftVal[i] = ~linkBit[i];
        AST_INV_LINK: assert property (@(posedge clk) disable iff (rst)
          strobes.shift |=> cells[i] != $past(linkBit[i])); // R5
      end else begin : gXor
        assign shiftVal[i] = linkBit[i] ^ cells[i];
        AST_XOR_LINK: assert property (@(posedge clk) disable iff (rst)
          strobes.shift |=> cells[i] == ($past(linkBit[i]) ^ $past(cells[i]))); // R4
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  cells <= '0;
    else if (strobes.capture) cells <= funcIn;
    else if (strobes.shift)   cells <= shiftVal;
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> cells == $past(funcIn)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (rst && $past(rst)) |-> cells == '0); // R1

  AST_LAST_CELL_VALID: assert property (@(posedge clk) disable iff (rst)
    strobes.shift |=> cells[LAST] == $past(shiftVal[LAST])); // R6

  generate
    if (GATE_KIND == GATE_XOR) begin : gZeroHold
      AST_XOR_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (strobes.shift && !scanIn && cells == '0) |=> cells == '0); // R10
    end
  endgenerate
endmodule

// File: rtl/obf_scan_chain.sv
module obf_scan_chain
  import scan_chain_pkg::*;
#(
  parameter int                   CHAIN_LEN = 8,
  parameter logic [CHAIN_LEN-1:0] LINK_MASK = 8'b1010_0101,
  parameter gateKind_e            GATE_KIND = GATE_XOR
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scanEn,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcIn,
  output logic [CHAIN_LEN-1:0] funcOut,
  output logic                 scanOut
);
  chainStrobe_t         strobes;
  logic [CHAIN_LEN-1:0] cells;

  obf_scan_ctrl uCtrl (
    .scanEn  (scanEn),
    .strobes (strobes)
  );

  obf_scan_datapath #(
    .CHAIN_LEN (CHAIN_LEN),
    .LINK_MASK (LINK_MASK),
    .GATE_KIND (GATE_KIND)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .scanIn  (scanIn),
    .funcIn  (funcIn),
    .cells   (cells)
  );

  assign funcOut = cells;
  assign scanOut = cells[CHAIN_LEN-1];

  AST_SCAN_TAP: assert property (@(posedge clk) disable iff (rst)
    !scanEn |=> scanOut == $past(funcIn[CHAIN_LEN-1])); // R6
endmodule

// File: tb/tb_obf_scan_chain.sv
`timescale 1ns/1ps
module tb_obf_scan_chain;
  import scan_chain_pkg::*;

  localparam int             N    = 6;
  localparam logic [N-1:0]   MASK = 6'b100101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scanEn = 1'b0;
  logic scanIn = 1'b0;
  logic [N-1:0] funcIn = '0;
  logic [N-1:0] outX, outI;
  logic soX, soI;

  logic [N-1:0] mX, mI;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  obf_scan_chain #(.CHAIN_LEN(N), .LINK_MASK(MASK), .GATE_KIND(GATE_XOR)) dut (
    .clk(clk), .rst(rst), .scanEn(scanEn), .scanIn(scanIn),
    .funcIn(funcIn), .funcOut(outX), .scanOut(soX));

  obf_scan_chain #(.CHAIN_LEN(N), .LINK_MASK(MASK), .GATE_KIND(GATE_INV)) dutInv (
    .clk(clk), .rst(rst), .scanEn(scanEn), .scanIn(scanIn),
    .funcIn(funcIn), .funcOut(outI), .scanOut(soI));

  function automatic logic [N-1:0] shiftModel(input logic [N-1:0] s, input logic si,
                                              input bit inv);
    logic [N-1:0] nx;
    for (int i = 0; i < N; i++) begin
      logic inBit;
      inBit = (i == 0) ? si : s[i-1];
      if (!MASK[i])  nx[i] = inBit;
      else if (inv)  nx[i] = ~inBit;
      else           nx[i] = inBit ^ s[i];
    end
    return nx;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    mX = '0;
    mI = '0;
    #1;
    chk("R1 xor funcOut", outX, '0);
    chk("R1 inv funcOut", outI, '0);
    chk("R1 scanOut", {{(N-2){1'b0}}, soX, soI}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Call at a falling edge; returns at the next falling edge after checking.
  task automatic step(input string tag, input logic en, input logic si, input logic [N-1:0] fi);
    scanEn = en;
    scanIn = si;
    funcIn = fi;
    if (en) begin
      mX = shiftModel(mX, si, 1'b0);
      mI = shiftModel(mI, si, 1'b1);
    end else begin
      mX = fi;
      mI = fi;
    end
    @(negedge clk);
    chk({tag, " xor"}, outX, mX);
    chk({tag, " inv"}, outI, mI);
    chk("R6 scanOut", {{(N-2){1'b0}}, soX, soI}, {{(N-2){1'b0}}, mX[N-1], mI[N-1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] seq;
    logic [N-1:0] rec;
    logic prevBit;

    doReset();

    // R7: mask bit 0 gates the scanIn link
    step("R7", 1'b1, 1'b1, '0);
    chk("R7 xor cell0", {{(N-1){1'b0}}, outX[0]}, {{(N-1){1'b0}}, 1'b1});
    chk("R7 inv cell0", {{(N-1){1'b0}}, outI[0]}, '0);

    // R9 / R10: reset, then shift zeros out of both variants
    doReset();
    seq = '0;
    rec = '0;
    for (int k = 0; k < N; k++) begin
      step("R9 R10", 1'b1, 1'b0, '0);
      seq[k] = soI;
      chk("R10 xor stream", {{(N-1){1'b0}}, soX}, '0);
    end
    prevBit = 1'b0;
    for (int k = 0; k < N; k++) begin
      rec[N-1-k] = seq[k] ^ prevBit;
      prevBit = seq[k];
    end
    chk("R9 recovered mask", rec, MASK);

    // R2 R3 R4 R5 R8: every capture word, then shift it out with a varied input stream
    for (int v = 0; v < (1 << N); v++) begin
      step("R2", 1'b0, 1'b1, N'(v));
      chk("R2 capture xor", outX, N'(v));
      chk("R2 capture inv", outI, N'(v));
      for (int k = 0; k < N; k++) begin
        step("R3 R4 R5 R8", 1'b1, 1'(((v * 5) + (k * 3)) >> 1), N'(~v));
      end
    end

    // R1: asynchronous clear after activity
    doReset();
    step("R1 after reset", 1'b1, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule